// File: doc/BRIEF.md
# Per-Channel Gain and Offset Corrector

This block sits between a multi-channel decimation chain and a serial output stage. It corrects a time-multiplexed stream of 24-bit two's-complement samples from four measurement channels. Each sample arrives with a channel index on a valid/ready input. The block first removes that channel's DC bias by subtracting the channel's offset value. It then scales the result by the channel's gain fraction, rounds it, saturates it, and sends it out on a valid/ready output together with its channel index.

A small register port holds the settings. There is one configuration word, one gain value per channel and one offset value per channel. Writes take effect on the clock edge. Reads are combinational. Gain and offset correction are enabled separately. A calibration mode tracks the mean of each channel with an exponential average and writes the estimate back into that channel's offset register. A host can start calibration, let it settle, read back the offsets, and then enable offset correction.

Back-pressure works as follows. When `out_valid` is high and `out_ready` is low, the output word is held unchanged and the whole two-stage pipeline stalls. `in_ready` equals `!out_valid || out_ready`, so a sample is accepted on any edge where `in_valid && in_ready`. Samples leave in the order they were accepted.

Top module: `gain_offset_corrector`

## Requirements
- R1: While `rst_n` is low and after reset: the configuration word is 0, every gain register reads 0x7FFFFF, every offset register reads 0, and `out_valid` is 0.
- R2: Register addresses are as follows. The configuration word is at 0x20. Gains for channels 0..3 are at 0x21..0x24. Offsets for channels 0..3 are at 0x25..0x28. Configuration bit 0 enables gain, bit 1 enables offset, and bits 2 and 3 together enable calibration. The configuration word keeps bits [3:0]. Writes to any other address are ignored, and reads of any other address return 0.
- R3: With gain and offset both disabled, the output word equals the input sample.
- R4: With offset enabled, the corrected value is d = x − offset[chan]. With offset disabled, d = x.
- R5: With gain enabled, let P = d·G. The output is (P + (P >>> 23) + 2^22) >>> 23, using arithmetic shifts. This is P/0x7FFFFF rounded to the nearest value. G = 0x7FFFFF gives d exactly, 0x3FFFFF gives about d/2, and 0 gives 0.
- R6: A gain register holding −0x800000 is applied as −0x7FFFFF, so the gain magnitude never exceeds unity.
- R7: Every output is saturated to the range −0x800000..0x7FFFFF.
- R8: An accepted sample appears on the output exactly 2 clocks after acceptance when not stalled. Its channel index travels with it, and order is preserved.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_chan` stay stable and `in_ready` is low. When `out_valid` is low, `in_ready` is high.
- R10: When configuration bits 2 and 3 are both set, each accepted sample x on channel c sets offset[c] to offset[c] + ((x − offset[c]) >>> 10). Other channels are unchanged. If only one of those bits is set, offsets do not move.
- R11: A register write to offset[c] in the same cycle as a calibration update of channel c takes priority.
- R12: A sample is corrected with the offset, gain and enables in force when it is accepted. Under calibration, this is the offset before that sample's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_chan | input | 2 | Channel index of input sample |
| in_data | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can accept |
| out_chan | output | 2 | Channel index of output sample |
| out_data | output | 24 | Corrected sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |

## Verification
Two situations are hard to reach from the ports. The first is a calibration update and a host write that target the same offset register in one cycle. The bench drives a sample for channel 0 and a write to that channel's offset on the same clock edge, then reads the register back. The second is a calibrated offset that has moved far from its start value. This needs hundreds of samples per channel, so the bench streams two interleaved constant channels long enough to do that. It tracks the exponential average step by step, and it also checks that outputs taken during calibration used the offset from before each update.

// File: rtl/gc_pkg.sv
package gc_pkg;
  // configuration word layout (bit 0 = gain, bit 1 = offset, bits 2,3 = calibration)
  typedef struct packed {
    logic cal_run;
    logic cal_arm;
    logic off_en;
    logic gain_en;
  } gc_cfg_t;

  localparam int unsigned CFG_W = 4;
endpackage

// File: rtl/gc_cal_step.sv
module gc_cal_step #(
  parameter int DW = 24,
  parameter int K  = 10
) (
  input  logic [DW-1:0] cur_off,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] next_off
);
  logic signed [DW:0] err;
  logic signed [DW:0] step;
  logic signed [DW:0] sum;

  always_comb begin
    err      = $signed({sample[DW-1], sample}) - $signed({cur_off[DW-1], cur_off});
    step     = err >>> K;
    sum      = $signed({cur_off[DW-1], cur_off}) + step;
    next_off = sum[DW-1:0];
  end
endmodule

// File: rtl/gc_regfile.sv
module gc_regfile
  import gc_pkg::*;
#(
  parameter int DW       = 24,
  parameter int NCH      = 4,
  parameter int AW       = 8,
  parameter int K        = 10,
  parameter int CFG_ADDR = 32'h20,
  parameter int GAIN_BASE = 32'h21,
  parameter int OFF_BASE  = 32'h25,
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              cal_hit,
  input  logic [CW-1:0]     cal_chan,
  input  logic [DW-1:0]     cal_sample,
  output gc_cfg_t           cfg,
  output logic [NCH*DW-1:0] gain_flat,
  output logic [NCH*DW-1:0] off_flat
);
  localparam logic [DW-1:0] UNITY = {1'b0, {(DW-1){1'b1}}};
  localparam logic [AW-1:0] A_CFG = AW'(CFG_ADDR);

  logic cal_on;
  assign cal_on = cfg.cal_arm && cfg.cal_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cfg <= '0;
    else if (reg_we && reg_addr == A_CFG) cfg <= gc_cfg_t'(reg_wdata[CFG_W-1:0]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_GAIN = AW'(GAIN_BASE + c);
    localparam logic [AW-1:0] A_OFF  = AW'(OFF_BASE + c);
    logic [DW-1:0] gain_q, off_q, off_nxt;

    gc_cal_step #(.DW(DW), .K(K)) u_step (
      .cur_off (off_q),
      .sample  (cal_sample),
      .next_off(off_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           gain_q <= UNITY;
      else if (reg_we && reg_addr == A_GAIN) gain_q <= reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       off_q <= '0;
      else if (reg_we && reg_addr == A_OFF)              off_q <= reg_wdata;
      else if (cal_on && cal_hit && cal_chan == CW'(c))  off_q <= off_nxt;
    end

    assign gain_flat[c*DW +: DW] = gain_q;
    assign off_flat[c*DW +: DW]  = off_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CFG) reg_rdata = DW'(cfg);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(GAIN_BASE + c)) reg_rdata = gain_flat[c*DW +: DW];
      if (reg_addr == AW'(OFF_BASE + c))  reg_rdata = off_flat[c*DW +: DW];
    end
  end
endmodule

// File: rtl/gc_datapath.sv
module gc_datapath #(
  parameter int DW = 24,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_chan,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] off_val,
  input  logic [DW-1:0] gain_val,
  input  logic          gain_en,
  input  logic          off_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_chan,
  output logic [DW-1:0] out_data
);
  localparam int PW = 2*DW + 3;
  localparam logic [DW-1:0] GMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] HALF  = PW'(1) << (DW-2);
  localparam logic signed [PW-1:0] SMAX  = PW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [PW-1:0] SMIN  = -(PW'(1) << (DW-1));

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 1: channel select done upstream, offset subtract
  logic              s1_valid;
  logic [CW-1:0]     s1_chan;
  logic signed [DW:0] s1_d;
  logic [DW-1:0]     s1_g;
  logic              s1_ge;
  logic signed [DW:0] x_ext, o_ext;

  assign x_ext = $signed({in_data[DW-1], in_data});
  assign o_ext = $signed({off_val[DW-1], off_val});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_d     <= '0;
      s1_g     <= '0;
      s1_ge    <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_chan <= in_chan;
        s1_d    <= off_en ? (x_ext - o_ext) : x_ext;
        s1_g    <= (gain_val == GMIN) ? (GMIN + DW'(1)) : gain_val;
        s1_ge   <= gain_en;
      end
    end
  end

  // stage 2: fractional gain, rounding, saturation
  logic signed [PW-1:0] d_w, g_w, prod, tot, scaled, pick;
  logic [DW-1:0] sat_val;

  always_comb begin
    d_w    = $signed({{(PW-DW-1){s1_d[DW]}}, s1_d});
    g_w    = $signed({{(PW-DW){s1_g[DW-1]}}, s1_g});
    prod   = d_w * g_w;
    tot    = prod + (prod >>> (DW-1)) + HALF;
    scaled = tot >>> (DW-1);
    pick   = s1_ge ? scaled : d_w;
    if (pick > SMAX)      sat_val = SMAX[DW-1:0];
    else if (pick < SMIN) sat_val = SMIN[DW-1:0];
    else                  sat_val = pick[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_chan <= s1_chan;
        out_data <= sat_val;
      end
    end
  end
endmodule

// File: rtl/gain_offset_corrector.sv
module gain_offset_corrector
  import gc_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int K   = 10,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_chan,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_chan,
  output logic [DW-1:0] out_data,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  gc_cfg_t           cfg;
  logic [CFG_W-1:0]  cfg_bits;
  logic [NCH*DW-1:0] gain_flat, off_flat;
  logic              accept;

  assign cfg_bits = cfg;
  assign accept   = in_valid && in_ready;

  gc_regfile #(.DW(DW), .NCH(NCH), .AW(AW), .K(K)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cal_hit   (accept),
    .cal_chan  (in_chan),
    .cal_sample(in_data),
    .cfg       (cfg),
    .gain_flat (gain_flat),
    .off_flat  (off_flat)
  );

  gc_datapath #(.DW(DW), .CW(CW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .off_val  (off_flat[in_chan*DW +: DW]),
    .gain_val (gain_flat[in_chan*DW +: DW]),
    .gain_en  (cfg.gain_en),
    .off_en   (cfg.off_en),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_chan (out_chan),
    .out_data (out_data)
  );
endmodule

// File: rtl/gc_checker.sv
module gc_checker #(
  parameter int DW  = 24,
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int CW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CW-1:0]     out_chan,
  input logic [DW-1:0]     out_data,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [3:0]        cfg_bits,
  input logic [NCH*DW-1:0] off_flat
);
  // R1
  always_comb begin
    if (!rst_n) reset_quiet_chk: assert (!out_valid);
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  // R9
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h20) |=> (cfg_bits == $past(reg_wdata[3:0])));

  // R10
  off_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_bits[2] && cfg_bits[3]) && !reg_we) |=> $stable(off_flat));

  // R11
  off_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h25) |=> (off_flat[DW-1:0] == $past(reg_wdata)));
endmodule

bind gain_offset_corrector gc_checker #(.DW(DW), .NCH(NCH), .AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_chan (out_chan),
  .out_data (out_data),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .cfg_bits (cfg_bits),
  .off_flat (off_flat)
);

// File: tb/sim_gain_offset_corrector.sv
`timescale 1ns/1ps
module sim_gain_offset_corrector;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [1:0] in_chan = 0, out_chan;
  logic [23:0] in_data = 0, out_data;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [23:0] reg_wdata = 0, reg_rdata;

  always #4 clk = ~clk;

  gain_offset_corrector u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  longint m_gain[4], m_off[4];
  logic [3:0] m_cfg;
  logic [1:0] q_chan[$];
  logic [23:0] q_data[$];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sx(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [23:0] model(longint x, int c);
    longint d, g, p, q;
    d = m_cfg[1] ? x - m_off[c] : x;
    if (m_cfg[0]) begin
      g = (m_gain[c] == -8388608) ? -8388607 : m_gain[c];
      p = d * g;
      q = (p + (p >>> 23) + 4194304) >>> 23;
    end else q = d;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q[23:0];
  endfunction

  // record acceptance: expected output, then calibration model step (R12)
  task automatic accept_model(int c, logic [23:0] x);
    q_chan.push_back(2'(c));
    q_data.push_back(model(sx(x), c));
    if (m_cfg[2] && m_cfg[3]) m_off[c] = m_off[c] + ((sx(x) - m_off[c]) >>> 10);
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (q_data.size() == 0) chk("R8 unexpected output", 1, 0);
      else begin
        chk("R8 channel tag", out_chan, q_chan.pop_front());
        chk("R3/R4/R5/R7 data", sx(out_data), sx(q_data.pop_front()));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    if (a == 8'h20) m_cfg = d[3:0];
    else if (a >= 8'h21 && a <= 8'h24) m_gain[a - 8'h21] = sx(d);
    else if (a >= 8'h25 && a <= 8'h28) m_off[a - 8'h25] = sx(d);
  endtask

  task automatic rd(logic [7:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic send(int c, logic [23:0] x);
    @(negedge clk);
    in_valid = 1; in_chan = 2'(c); in_data = x; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    accept_model(c, x);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    chk("R8 all outputs delivered", q_data.size(), 0);
  endtask

  task automatic t_reset();
    logic [23:0] v;
    chk("R1 out_valid in reset", out_valid, 0);
    rd(8'h20, v); chk("R1 cfg reset", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h21 + c), v); chk("R1 gain reset", v, 24'h7FFFFF);
      rd(8'(8'h25 + c), v); chk("R1 offset reset", v, 0);
    end
  endtask

  task automatic t_regmap();
    logic [23:0] v;
    wr(8'h23, 24'h123456); rd(8'h23, v); chk("R2 gain ch2", v, 24'h123456);
    wr(8'h28, 24'hABCDEF); rd(8'h28, v); chk("R2 offset ch3", v, 24'hABCDEF);
    wr(8'h20, 24'hFFFFF3); rd(8'h20, v); chk("R2 cfg bits", v, 24'h3);
    wr(8'h29, 24'h555555); rd(8'h29, v); chk("R2 unmapped read", v, 0);
    wr(8'h1F, 24'h555555); rd(8'h1F, v); chk("R2 unmapped read low", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h21 + c), v); chk("R2 gain untouched", v, (c == 2) ? 24'h123456 : 24'h7FFFFF);
      rd(8'(8'h25 + c), v); chk("R2 offset untouched", v, (c == 3) ? 24'hABCDEF : 0);
    end
    wr(8'h20, 0); wr(8'h23, 24'h7FFFFF); wr(8'h28, 0);
  endtask

  task automatic t_bypass();
    wr(8'h25, 24'h001000); wr(8'h21, 24'h100000);
    send(0, 24'h7FFFFF); send(1, 24'h800000); send(2, 24'h000001); send(3, 24'hFFF123);
    drain(); // R3
  endtask

  task automatic t_offset();
    wr(8'h20, 24'h2);
    wr(8'h26, 24'hFFFF00); wr(8'h27, 24'h000001); wr(8'h28, 24'h000400);
    send(0, 24'h002000);      // R4
    send(1, 24'h7FFFF0);      // R7 positive clip
    send(2, 24'h800000);      // R7 negative clip
    send(3, 24'h000100);      // R4 negative result
    drain();
  endtask

  task automatic t_gain();
    wr(8'h20, 24'h1);
    wr(8'h21, 24'h7FFFFF); wr(8'h22, 24'h3FFFFF); wr(8'h23, 24'h000000); wr(8'h24, 24'h800000);
    send(0, 24'h654321); send(0, 24'h9ABCDE);  // R5 unity
    send(1, 24'h400000); send(1, 24'hC00001);  // R5 half
    send(2, 24'h7FFFFF);                        // R5 zero
    send(3, 24'h800000); send(3, 24'h123457);   // R6
    wr(8'h20, 24'h3); wr(8'h25, 24'h000010);
    send(0, 24'h800000); send(1, 24'h7FFFFF);   // R4+R5+R7
    drain();
    wr(8'h20, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1; in_chan = 2; in_data = 24'h0ABCDE; #1;
    accept_model(2, 24'h0ABCDE);
    @(posedge clk); #1; in_valid = 0;
    @(negedge clk); chk("R8 not valid after 1 clock", out_valid, 0);
    @(negedge clk); chk("R8 valid after 2 clocks", out_valid, 1);
    drain();
  endtask

  task automatic t_backpressure();
    logic [23:0] held;
    @(negedge clk); out_ready = 0;
    send(1, 24'h111111);
    send(2, 24'h222222);
    @(negedge clk); #1;
    chk("R9 in_ready low when stalled", in_ready, 0);
    held = out_data;
    repeat (4) @(negedge clk);
    #1 chk("R9 data held", out_data, held);
    chk("R9 valid held", out_valid, 1);
    @(negedge clk); out_ready = 1;
    drain();
  endtask

  task automatic t_cal();
    logic [23:0] v;
    for (int c = 0; c < 4; c++) wr(8'(8'h25 + c), 0);
    wr(8'h20, 24'h6);                  // only one calibration bit: R10 no motion
    send(1, 24'h300000); send(1, 24'h300000);
    drain();
    rd(8'h26, v); chk("R10 half-armed no update", v, 0);
    wr(8'h20, 24'hE);
    for (int i = 0; i < 300; i++) begin
      send(1, 24'h200000);
      send(3, 24'hEDCBAA);
    end
    drain();                            // R12 via scoreboard
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h25 + c), v);
      chk("R10 calibrated offset", sx(v), m_off[c]);
    end
  endtask

  task automatic t_priority();
    logic [23:0] v;
    wr(8'h25, 24'h000500);
    @(negedge clk);
    in_valid = 1; in_chan = 0; in_data = 24'h400000;
    reg_we = 1; reg_addr = 8'h25; reg_wdata = 24'h000111; #1;
    chk("R11 in_ready", in_ready, 1);
    accept_model(0, 24'h400000);
    m_off[0] = 24'h000111;
    @(posedge clk); #1;
    in_valid = 0; reg_we = 0;
    rd(8'h25, v); chk("R11 write wins", v, 24'h000111);
    drain();
    wr(8'h20, 0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin m_gain[c] = 24'h7FFFFF; m_off[c] = 0; end
    m_cfg = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_regmap();
    t_bypass();
    t_offset();
    t_gain();
    t_latency();
    t_backpressure();
    t_cal();
    t_priority();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule